// File: doc/BRIEF.md
# Dual-Slope Double-Buffered PWM Timer

This block is a 16-bit timer that counts up from zero to a programmable ceiling and then back down to zero, over and over. Two compare channels watch the count and drive PWM pins. Because a channel's pin changes once on the way up and once on the way down, the high and low intervals sit symmetrically around the turning points. The period is set by the ceiling, which is either a directly written ceiling register or the active compare value of channel A.

Software writes compare values into holding buffers. Those buffers move into the active compare registers only on the tick at which the count arrives at zero. So a change to a duty cycle, or to the ceiling when channel A supplies it, never breaks a half-period in two. The counter moves only on ticks of an external prescaled enable. Sticky flags report arrival at zero, arrival at the ceiling and compare matches.

Top module: `dualslope_pwm`

## Requirements
- R1: On each cycle with `tickEn` high the count moves by one step. It goes up from 0 to the ceiling, then down to 0, then up again. With `tickEn` low the count holds its value.
- R2: With a ceiling of 0 the count stays at 0 on every tick. Each such tick counts as an arrival at zero.
- R3: With `topSel` = 0 the ceiling is the ceiling register (write address 0), and a write to it takes effect at once. With `topSel` = 1 the ceiling is the active compare value of channel A.
- R4: Writes to address 1 (channel A) or address 2 (channel B) fill holding buffers. A buffer is copied to the active compare register on the tick at which the count becomes 0. Until then, the output and the ceiling keep the old active value.
- R5: `flagOvf` is set on the tick at which the count becomes 0.
- R6: `flagTop` is set on the tick at which the count reaches the ceiling going up, but only while `topSel` = 0. `flagMatchA` and `flagMatchB` are set on a compare match of their channel. With `topSel` = 1, reaching the ceiling is a channel A match.
- R7: The flags are sticky. They are cleared by pulsing `flagClr`, with bit 0 for `flagOvf`, bit 1 for `flagTop`, bit 2 for `flagMatchA` and bit 3 for `flagMatchB`.
- R8: Mode 2 gives non-inverted PWM: a match while counting up drives the pin low, and a match while counting down drives it high.
- R9: Mode 3 gives inverted PWM: a match while counting up drives the pin high, and a match while counting down drives it low.
- R10: In modes 0 and 1 the pin is held low.
- R11: A channel whose active compare value is above the ceiling gets no match, no flag and no pin change.
- R12: While `topSel` = 1, `pwmA` is held low. While `topSel` = 0, channel A works as a normal PWM channel.
- R13: A match is the arrival of the count at the active compare value on a tick, judged with the values active before that tick. After reset the count, the flags and both pins are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| tickEn | input | 1 | Prescaled count enable |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | 0 ceiling, 1 channel A buffer, 2 channel B buffer |
| wrData | input | 16 | Write data |
| topSel | input | 1 | Ceiling source: 0 ceiling register, 1 channel A |
| modeA | input | 2 | Channel A output mode |
| modeB | input | 2 | Channel B output mode |
| flagClr | input | 4 | Write-one-to-clear flag pulses |
| count | output | 16 | Current count |
| pwmA | output | 1 | Channel A PWM pin |
| pwmB | output | 1 | Channel B PWM pin |
| flagOvf | output | 1 | Arrived at zero |
| flagTop | output | 1 | Reached ceiling register value |
| flagMatchA | output | 1 | Channel A match |
| flagMatchB | output | 1 | Channel B match |

## Verification
The main PWM function is run through a set of ceiling and compare pairs, in both output modes and on both channels. Some pairs put the compare value near zero, some near the ceiling, and some in the middle, so an error in the up/down direction or an off-by-one at the match shows up at distinct counts. Directed runs rewrite a buffer partway through a period to show that the old compare value or ceiling stays in force until the count reaches zero. Further runs cover a compare value above the ceiling, a ceiling of zero, a ceiling taken from channel A, the disconnected modes and a stalled tick, so that each of these can be told apart from ordinary counting.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef struct packed {
    logic step;      // a tick moves the counter this cycle
    logic stepUp;    // direction of that move
    logic atBottom;  // count becomes zero on this tick
    logic atTop;     // count reaches the ceiling going up
  } ctrlStrobe_t;

  localparam logic [1:0] ADDR_TOP  = 2'd0;
  localparam logic [1:0] ADDR_CMPA = 2'd1;
  localparam logic [1:0] ADDR_CMPB = 2'd2;

  localparam int FLAG_OVF = 0;
  localparam int FLAG_TOP = 1;
  localparam int FLAG_MA  = 2;
  localparam int FLAG_MB  = 3;
  localparam int NFLAGS   = 4;
endpackage

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tickEn,
  input  logic [CW-1:0] topVal,
  output logic [CW-1:0] count,
  output logic [CW-1:0] nextCount,
  output ctrlStrobe_t   strobe
);
  logic dirUp, nextUp;

  // Next state of the triangle walk
  always_comb begin
    nextCount = count;
    nextUp    = dirUp;
    if (topVal == '0) begin
      nextCount = '0;
      nextUp    = 1'b1;
    end else if (dirUp) begin
      if (count >= topVal) begin
        nextCount = count - 1'b1;
        nextUp    = 1'b0;
      end else begin
        nextCount = count + 1'b1;
      end
    end else begin
      if (count == '0) begin
        nextCount = {{(CW-1){1'b0}}, 1'b1};
        nextUp    = 1'b1;
      end else begin
        nextCount = count - 1'b1;
      end
    end
  end

  always_comb begin
    strobe.step     = tickEn;
    strobe.stepUp   = nextCount > count;
    strobe.atBottom = tickEn && (nextCount == '0);
    strobe.atTop    = tickEn && nextUp && (topVal != '0) && (nextCount == topVal);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
      dirUp <= 1'b1;
    end else if (tickEn) begin
      count <= nextCount;
      dirUp <= nextUp;
    end
  end
endmodule

// File: rtl/pwm_datapath.sv
module pwm_datapath
  import pwm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [CW-1:0]     wrData,
  input  logic              topSel,
  input  logic [1:0]        modeA,
  input  logic [1:0]        modeB,
  input  logic [NFLAGS-1:0] flagClr,
  input  ctrlStrobe_t       strobe,
  input  logic [CW-1:0]     nextCount,
  output logic [CW-1:0]     topVal,
  output logic [CW-1:0]     cmpActA,
  output logic [CW-1:0]     cmpActB,
  output logic              pwmA,
  output logic              pwmB,
  output logic [NFLAGS-1:0] flags
);
  localparam int NCH = 2;

  logic [CW-1:0]           fixedTop;
  logic [NCH-1:0][CW-1:0]  cmpBuf, cmpAct;
  logic [NCH-1:0][1:0]     mode;
  logic [NCH-1:0]          hit, outBit, pin;
  logic [NFLAGS-1:0]       setVec;

  assign mode = {modeB, modeA};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fixedTop <= '0;
      cmpBuf   <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_TOP:  fixedTop  <= wrData;
        ADDR_CMPA: cmpBuf[0] <= wrData;
        ADDR_CMPB: cmpBuf[1] <= wrData;
        default:   ;
      endcase
    end
  end

  // Double buffer: active values change only at the bottom
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                cmpAct <= '0;
    else if (strobe.atBottom) cmpAct <= cmpBuf;
  end

  assign topVal  = topSel ? cmpAct[0] : fixedTop;
  assign cmpActA = cmpAct[0];
  assign cmpActB = cmpAct[1];

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic chOut;
    assign hit[ch] = strobe.step && (topVal != '0) &&
                     (nextCount == cmpAct[ch]) && (cmpAct[ch] <= topVal);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)        chOut <= 1'b0;
      else if (hit[ch]) chOut <= mode[ch][0] ? strobe.stepUp : !strobe.stepUp;
    end
    assign outBit[ch] = chOut;
    assign pin[ch]    = mode[ch][1] & outBit[ch];
  end

  assign pwmA = pin[0] & ~topSel;
  assign pwmB = pin[1];

  always_comb begin
    setVec           = '0;
    setVec[FLAG_OVF] = strobe.atBottom;
    setVec[FLAG_TOP] = strobe.atTop & ~topSel;
    setVec[FLAG_MA]  = hit[0];
    setVec[FLAG_MB]  = hit[1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flags <= '0;
    else       flags <= (flags & ~flagClr) | setVec;
  end
endmodule

// File: rtl/dualslope_pwm.sv
module dualslope_pwm
  import pwm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tickEn,
  input  logic          wrEn,
  input  logic [1:0]    wrAddr,
  input  logic [CW-1:0] wrData,
  input  logic          topSel,
  input  logic [1:0]    modeA,
  input  logic [1:0]    modeB,
  input  logic [3:0]    flagClr,
  output logic [CW-1:0] count,
  output logic          pwmA,
  output logic          pwmB,
  output logic          flagOvf,
  output logic          flagTop,
  output logic          flagMatchA,
  output logic          flagMatchB
);
  ctrlStrobe_t       strobe;
  logic [CW-1:0]     nextCount, topVal, cmpActA, cmpActB;
  logic [NFLAGS-1:0] flags;

  pwm_ctrl #(.CW(CW)) u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .topVal(topVal),
    .count(count), .nextCount(nextCount), .strobe(strobe)
  );

  pwm_datapath #(.CW(CW)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .topSel(topSel), .modeA(modeA), .modeB(modeB), .flagClr(flagClr),
    .strobe(strobe), .nextCount(nextCount), .topVal(topVal),
    .cmpActA(cmpActA), .cmpActB(cmpActB), .pwmA(pwmA), .pwmB(pwmB),
    .flags(flags)
  );

  assign flagOvf    = flags[FLAG_OVF];
  assign flagTop    = flags[FLAG_TOP];
  assign flagMatchA = flags[FLAG_MA];
  assign flagMatchB = flags[FLAG_MB];
endmodule

// File: rtl/pwm_checker.sv
module pwm_checker #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          tickEn,
  input logic [CW-1:0] count,
  input logic [CW-1:0] topVal,
  input logic [CW-1:0] cmpActB,
  input logic          flagOvf,
  input logic          flagTop,
  input logic          flagMatchB
);
  p_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> count == $past(count));

  p_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    tickEn |=> (count == $past(count) + 1'b1) || (count == $past(count) - 1'b1) ||
               (count == '0 && $past(count) == '0));

  p_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && topVal == '0) |=> count == '0);

  p_ovf_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagOvf) |-> count == '0);

  p_top_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagTop) |-> count == $past(topVal));

  p_nomatch_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagMatchB) |-> ($past(cmpActB) <= $past(topVal)) && (count == $past(cmpActB)));
endmodule

bind dualslope_pwm pwm_checker #(.CW(CW)) u_chk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .count(count), .topVal(topVal),
  .cmpActB(cmpActB), .flagOvf(flagOvf), .flagTop(flagTop), .flagMatchB(flagMatchB)
);

// File: tb/dualslope_pwm_bench.sv
`timescale 1ns/1ps
module dualslope_pwm_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0, wrEn = 1'b0, topSel = 1'b0;
  logic [1:0]  wrAddr = '0, modeA = '0, modeB = '0;
  logic [15:0] wrData = '0;
  logic [3:0]  flagClr = '0;
  logic [15:0] count;
  logic        pwmA, pwmB, flagOvf, flagTop, flagMatchA, flagMatchB;

  int nChecks = 0;
  int nErrors = 0;

  always #2.5 clk = ~clk;

  dualslope_pwm u_dualslope_pwm (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .topSel(topSel), .modeA(modeA), .modeB(modeB),
    .flagClr(flagClr), .count(count), .pwmA(pwmA), .pwmB(pwmB),
    .flagOvf(flagOvf), .flagTop(flagTop), .flagMatchA(flagMatchA),
    .flagMatchB(flagMatchB)
  );

  // {ceiling, cmpA, cmpB, modeA, modeB}
  localparam logic [51:0] VEC [0:5] = '{
    {16'd10, 16'd4,  16'd7,  2'd2, 2'd3},
    {16'd7,  16'd3,  16'd3,  2'd3, 2'd2},
    {16'd20, 16'd15, 16'd1,  2'd2, 2'd2},
    {16'd5,  16'd1,  16'd4,  2'd2, 2'd3},
    {16'd12, 16'd6,  16'd11, 2'd3, 2'd2},
    {16'd3,  16'd2,  16'd1,  2'd2, 2'd2}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    wrEn = 1'b1; wrAddr = a; wrData = 16'(d);
    cyc(1);
    wrEn = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0; tickEn = 1'b0; wrEn = 1'b0; flagClr = '0;
    topSel = 1'b0; modeA = '0; modeB = '0;
    cyc(2);
    rstN = 1'b1;
    cyc(1);
  endtask

  function automatic bit expPin(input int mode, input bit up, input int cnt, input int cmp);
    bit nonInv;
    nonInv = (up && cnt < cmp) || (!up && cnt <= cmp);
    if (mode == 2) return nonInv;
    if (mode == 3) return !nonInv;
    return 1'b0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nErrors++;
    $display("FAIL R1 watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

  initial begin
    // Table walk: R8 R9 R12 (channel A free with topSel 0), R3 ceiling register
    for (int v = 0; v < 6; v++) begin
      int top, ca, cb, ma, mb, prev;
      top = int'(VEC[v][51:36]); ca = int'(VEC[v][35:20]); cb = int'(VEC[v][19:4]);
      ma = int'(VEC[v][3:2]);    mb = int'(VEC[v][1:0]);
      doReset();
      wr(2'd0, top); wr(2'd1, ca); wr(2'd2, cb);
      modeA = 2'(ma); modeB = 2'(mb);
      tickEn = 1'b1;
      cyc(6 * top);
      chk(count == 0, "R1 period end", int'(count), 0);
      prev = int'(count);
      for (int i = 0; i < 2 * top; i++) begin
        bit up;
        cyc(1);
        up = int'(count) > prev;
        chk(int'(count) <= top && (int'(count) == prev + 1 || int'(count) == prev - 1),
            "R1 R3 step within ceiling", int'(count), prev);
        chk(pwmA == expPin(ma, up, int'(count), ca), "R8 R9 R12 pwmA", pwmA, expPin(ma, up, int'(count), ca));
        chk(pwmB == expPin(mb, up, int'(count), cb), "R8 R9 pwmB", pwmB, expPin(mb, up, int'(count), cb));
        prev = int'(count);
      end
    end

    // R13 reset state
    doReset();
    chk(count == 0, "R13 reset count", int'(count), 0);
    chk({flagOvf, flagTop, flagMatchA, flagMatchB} == 4'b0, "R13 reset flags",
        {flagOvf, flagTop, flagMatchA, flagMatchB}, 0);
    chk(!pwmA && !pwmB, "R13 reset pins", {pwmA, pwmB}, 0);

    // R1 stall with tickEn low
    wr(2'd0, 10);
    tickEn = 1'b1; cyc(3);
    chk(count == 3, "R1 counting", int'(count), 3);
    tickEn = 1'b0; cyc(4);
    chk(count == 3, "R1 hold", int'(count), 3);

    // R2 ceiling zero
    doReset();
    tickEn = 1'b1; cyc(5);
    chk(count == 0, "R2 zero ceiling", int'(count), 0);
    chk(flagOvf == 1'b1, "R2 zero ceiling bottom", flagOvf, 1);

    // R5 R6 R7 flags
    doReset();
    wr(2'd0, 6); wr(2'd1, 2); wr(2'd2, 3);
    tickEn = 1'b1; cyc(6);
    chk(count == 6 && flagTop, "R6 top flag", flagTop, 1);
    chk(!flagOvf, "R5 no early ovf", flagOvf, 0);
    cyc(6);
    chk(count == 0 && flagOvf, "R5 ovf at bottom", flagOvf, 1);
    tickEn = 1'b0; flagClr = 4'hF; cyc(1); flagClr = '0;
    chk({flagOvf, flagTop, flagMatchA, flagMatchB} == 4'b0, "R7 clear",
        {flagOvf, flagTop, flagMatchA, flagMatchB}, 0);
    tickEn = 1'b1; cyc(1);
    chk(!flagMatchA, "R6 no matchA at 1", flagMatchA, 0);
    cyc(1);
    chk(count == 2 && flagMatchA, "R6 matchA at 2", flagMatchA, 1);
    chk(!flagMatchB, "R6 no matchB at 2", flagMatchB, 0);
    cyc(1);
    chk(count == 3 && flagMatchB, "R6 matchB at 3", flagMatchB, 1);
    chk(flagMatchA, "R7 sticky", flagMatchA, 1);

    // R4 double buffer
    doReset();
    wr(2'd0, 10); wr(2'd1, 4); modeA = 2'd2;
    tickEn = 1'b1; cyc(66);
    chk(count == 6, "R4 setup", int'(count), 6);
    tickEn = 1'b0; wr(2'd1, 8); tickEn = 1'b1;
    cyc(7);
    chk(count == 7 && pwmA == 1'b0, "R4 old compare kept", pwmA, 0);
    cyc(7 + 20 + 12);
    chk(count == 8 && pwmA == 1'b1, "R4 new compare after bottom", pwmA, 1);

    // R3 R12 R4 ceiling from channel A
    doReset();
    topSel = 1'b1; modeA = 2'd2;
    wr(2'd1, 5);
    tickEn = 1'b1; cyc(1);
    chk(count == 0, "R3 load at bottom", int'(count), 0);
    cyc(5);
    chk(count == 5, "R3 peak from channel A", int'(count), 5);
    chk(flagMatchA && !flagTop, "R6 top via matchA", {flagMatchA, flagTop}, 2);
    chk(!pwmA, "R12 pwmA held low", pwmA, 0);
    tickEn = 1'b0; wr(2'd1, 8); tickEn = 1'b1;
    cyc(1);
    chk(count == 4, "R4 ceiling kept until bottom", int'(count), 4);
    cyc(4 + 8);
    chk(count == 8, "R4 new ceiling", int'(count), 8);
    cyc(1);
    chk(count == 7, "R3 turn at new ceiling", int'(count), 7);
    chk(!pwmA, "R12 pwmA held low later", pwmA, 0);

    // R11 compare above ceiling
    doReset();
    wr(2'd0, 10); wr(2'd2, 20); modeB = 2'd3;
    tickEn = 1'b1; cyc(20);
    tickEn = 1'b0; flagClr = 4'hF; cyc(1); flagClr = '0; tickEn = 1'b1;
    for (int k = 0; k < 8; k++) begin
      cyc(5);
      chk(!pwmB, "R11 pin unchanged", pwmB, 0);
    end
    chk(!flagMatchB, "R11 no match flag", flagMatchB, 0);

    // R10 disconnected modes
    doReset();
    wr(2'd0, 6); wr(2'd1, 3); wr(2'd2, 3);
    modeA = 2'd0; modeB = 2'd1;
    tickEn = 1'b1;
    for (int k = 0; k < 6; k++) begin
      cyc(6);
      chk(!pwmA && !pwmB, "R10 pins low", {pwmA, pwmB}, 0);
    end
    tickEn = 1'b0; modeA = 2'd2; #1;
    chk(count == 0 && pwmA, "R10 pin reconnects", pwmA, 1);

    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end
endmodule